// File: doc/BRIEF.md
# Bidirectional GPIO Port with Per-Pin Peripheral Override

This block controls eight general-purpose pins from a CPU register bus. Software owns two registers: an output value latch and a direction latch in which a 1 means the pin is an input (driver off) and a 0 means the pin drives the output value. Both are written from the bus data word, and a single address bit picks which one a write or read touches.

Any pin can be handed to an on-chip peripheral through a per-pin select. While a pin is selected, the peripheral supplies both the driven value and the driver enable, so it can force the pin to output or to input whatever the direction latch holds. The latch itself is never changed by such an override. Pin levels are brought through a two-flop synchronizer. The synchronized level is returned on port reads and also fed to the peripheral input paths. A port read therefore shows the live pin, not the output latch.

Top module: `gpio_port_ovr`

## Requirements
- R1: After a synchronous active-low reset, every direction bit reads 1, the output latch holds 0, no pin driver is enabled (`pin_oe` = 0) and `bus_rvalid` is 0.
- R2: A write with `bus_addr` = 0 loads `bus_wdata` into the output latch and leaves the direction latch unchanged. A write with `bus_addr` = 1 loads the direction latch and leaves the output latch unchanged.
- R3: For a pin whose `periph_sel` bit is 0, `pin_oe` is the inverse of its direction bit. When the direction bit is 0, `pin_out` carries that pin's output latch bit.
- R4: For a pin whose `periph_sel` bit is 1, `pin_out` equals `periph_dout` and `pin_oe` equals `periph_oe`, whatever the direction bit holds.
- R5: A read with `bus_addr` = 1 returns the direction latch contents even while overrides are active. A read-modify-write of that value stores exactly the written word, and the override never writes the latch.
- R6: A read with `bus_addr` = 0 returns the synchronized pin level, not the output latch.
- R7: A change on `pin_in` appears on `periph_din` after exactly two rising clock edges, and not after one.
- R8: `bus_rvalid` is 1 in exactly the cycle after the cycle in which `bus_rd` was sampled high, and `bus_rdata` is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 1 | Register select: 0 output/port, 1 direction |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| periph_sel | input | 8 | Per-pin hand-over to peripheral |
| periph_dout | input | 8 | Peripheral output value per pin |
| periph_oe | input | 8 | Peripheral driver enable per pin |
| pin_in | input | 8 | Level seen on each pin |
| pin_out | output | 8 | Value driven on each pin |
| pin_oe | output | 8 | Driver enable per pin (1 = drive) |
| periph_din | output | 8 | Synchronized pin level to peripherals |

## Verification
The bench builds the block with its default parameters: eight pins and a two-stage synchronizer. The narrow width lets every pin be set into a distinct mix of selected and unselected, input and output, within a single pattern. That mix puts R3 and R4 side by side in the same word. The two-stage depth makes the exact input latency of R7 observable edge by edge.

// File: rtl/gpio_pkg.sv
// Package: shared register-address encoding for the GPIO port.
package gpio_pkg;
    // Register selected by the single bus address bit.
    typedef enum logic {
        ADDR_PORT = 1'b0,   // output latch on write, pin level on read
        ADDR_DIR  = 1'b1    // direction latch (1 = input)
    } gpio_addr_e;
endpackage

// File: rtl/gpio_sync.sv
// Module: gpio_sync
// Brings asynchronous pin levels into the clock domain through a chain of
// STAGES flops per bit. Assumes STAGES >= 2. The chain is deliberately not
// reset: it is flushed by the clock while reset is held, so reset must be
// held for at least STAGES cycles.
module gpio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    // Shift the pin levels one stage deeper on every edge.
    always_ff @(posedge clk) begin
        chain_q[0] <= d_async;
        for (int s = 1; s < STAGES; s++) begin
            chain_q[s] <= chain_q[s-1];
        end
    end

    assign q_sync = chain_q[STAGES-1];

    generate
        if (STAGES == 2) begin : g_lat_chk
            AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
                q_sync == $past(d_async, 2)); // R7
        end
    endgenerate
endmodule

// File: rtl/gpio_regs.sv
// Module: gpio_regs
// Holds the output latch and direction latch and serves bus reads.
// Assumes bus_wr and bus_rd are single-cycle strobes sampled on the rising
// edge. Read data is registered and valid one cycle after the strobe.
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [WIDTH-1:0] bus_wdata,
    input  logic [WIDTH-1:0] pin_sync,
    output logic [WIDTH-1:0] bus_rdata,
    output logic             bus_rvalid,
    output logic [WIDTH-1:0] out_q,
    output logic [WIDTH-1:0] dir_q
);
    logic wr_out_stb;
    logic wr_dir_stb;

    // Split the write enable into one strobe per latch.
    always_comb begin
        wr_out_stb = bus_wr && (gpio_addr_e'(bus_addr) == ADDR_PORT);
        wr_dir_stb = bus_wr && (gpio_addr_e'(bus_addr) == ADDR_DIR);
    end

    // Output latch: cleared on reset, loaded by its own strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else if (wr_out_stb) begin
            out_q <= bus_wdata;
        end
    end

    // Direction latch: all inputs on reset, loaded by its own strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '1;
        end else if (wr_dir_stb) begin
            dir_q <= bus_wdata;
        end
    end

    // Registered read path: direction latch or synchronized pin level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            bus_rvalid <= bus_rd;
            if (bus_rd) begin
                bus_rdata <= (gpio_addr_e'(bus_addr) == ADDR_DIR) ? dir_q : pin_sync;
            end
        end
    end

    AST_RVALID_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid); // R8
    AST_RVALID_ONLY_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> !bus_rvalid); // R8
    AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr) |=> $stable(dir_q)); // R5
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && !bus_addr) |=> $stable(out_q)); // R2
endmodule

// File: rtl/gpio_pad_mux.sv
// Module: gpio_pad_mux
// Per pin, chooses between port control and peripheral control of the
// driver. Purely combinational. A selected pin takes both value and enable
// from the peripheral. An unselected pin drives its latch bit when the
// direction bit is 0.
module gpio_pad_mux #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] out_q,
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] periph_sel,
    input  logic [WIDTH-1:0] periph_dout,
    input  logic [WIDTH-1:0] periph_oe,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_oe
);
    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_pin
            // Route value and enable for one pin.
            always_comb begin
                if (periph_sel[i]) begin
                    pin_out[i] = periph_dout[i];
                    pin_oe[i]  = periph_oe[i];
                end else begin
                    pin_out[i] = out_q[i];
                    pin_oe[i]  = ~dir_q[i];
                end
            end
        end
    endgenerate
endmodule

// File: rtl/gpio_port_ovr.sv
// Module: gpio_port_ovr (top)
// Bidirectional GPIO port: register bank, pin synchronizer and per-pin
// peripheral override mux. Pin electrical behaviour is modelled as a
// driver enable plus a sampled input value.
module gpio_port_ovr #(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [WIDTH-1:0] bus_wdata,
    output logic [WIDTH-1:0] bus_rdata,
    output logic             bus_rvalid,
    input  logic [WIDTH-1:0] periph_sel,
    input  logic [WIDTH-1:0] periph_dout,
    input  logic [WIDTH-1:0] periph_oe,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_oe,
    output logic [WIDTH-1:0] periph_din
);
    logic [WIDTH-1:0] pin_sync;
    logic [WIDTH-1:0] out_q;
    logic [WIDTH-1:0] dir_q;

    gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pin_in),
        .q_sync  (pin_sync)
    );

    gpio_regs #(.WIDTH(WIDTH)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_wdata  (bus_wdata),
        .pin_sync   (pin_sync),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .out_q      (out_q),
        .dir_q      (dir_q)
    );

    gpio_pad_mux #(.WIDTH(WIDTH)) u_mux (
        .out_q       (out_q),
        .dir_q       (dir_q),
        .periph_sel  (periph_sel),
        .periph_dout (periph_dout),
        .periph_oe   (periph_oe),
        .pin_out     (pin_out),
        .pin_oe      (pin_oe)
    );

    assign periph_din = pin_sync;

    AST_PORT_OWNS_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_oe ^ ~dir_q) & ~periph_sel) == '0); // R3
    AST_PERIPH_OWNS_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
        (((pin_oe ^ periph_oe) | (pin_out ^ periph_dout)) & periph_sel) == '0); // R4
    AST_RESET_DRIVERS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> ((pin_oe & ~periph_sel) == '0)); // R1
endmodule

// File: tb/gpio_port_ovr_test.sv
// Scoreboard bench for gpio_port_ovr: read requests push expected words into
// a queue, a monitor pops and compares on each bus_rvalid.
module gpio_port_ovr_test;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_addr = 1'b0;
    logic         bus_wr = 1'b0;
    logic         bus_rd = 1'b0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic         bus_rvalid;
    logic [W-1:0] periph_sel = '0;
    logic [W-1:0] periph_dout = '0;
    logic [W-1:0] periph_oe = '0;
    logic [W-1:0] pin_in = '0;
    logic [W-1:0] pin_out;
    logic [W-1:0] pin_oe;
    logic [W-1:0] periph_din;

    int tests = 0;
    int fails = 0;
    logic [W-1:0] exp_q[$];
    string        tag_q[$];
    logic [W-1:0] rd_word;

    always #4 clk = ~clk;   // 125 MHz

    gpio_port_ovr uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .periph_sel(periph_sel),
        .periph_dout(periph_dout), .periph_oe(periph_oe), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .periph_din(periph_din)
    );

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: compare every returned read word against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                tests++; fails++;
                $display("FAIL R8: unexpected rvalid, data %h expected none", bus_rdata);
            end else begin
                rd_word = bus_rdata;
                check(tag_q.pop_front(), rd_word, exp_q.pop_front());
            end
        end
    end

    task automatic bus_write(input logic a, input logic [W-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic a, input logic [W-1:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
        @(negedge clk);
        check("R8 rvalid single cycle", {7'd0, bus_rvalid}, 8'h00);
        check("R8 scoreboard drained", exp_q.size(), 8'h00);
    endtask

    // Watchdog.
    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 pin_oe after reset", pin_oe, 8'h00);
        check("R1 rvalid after reset", {7'd0, bus_rvalid}, 8'h00);
        bus_read(1'b1, 8'hFF, "R1 direction reset");
        bus_read(1'b0, 8'h00, "R1 port read after reset");

        // R2: each strobe touches only its own latch.
        bus_write(1'b0, 8'hA5);
        bus_read(1'b1, 8'hFF, "R2 dir unchanged by port write");
        check("R3 all inputs, no drive", pin_oe, 8'h00);
        bus_write(1'b1, 8'hF0);
        #1;
        check("R3 low nibble driven", pin_oe, 8'h0F);
        check("R2/R3 latch on driven pins", pin_out & 8'h0F, 8'h05);

        // R6: port read returns the pin level, not the latch (A5).
        @(negedge clk); pin_in = 8'h3C;
        repeat (3) @(negedge clk);
        bus_read(1'b0, 8'h3C, "R6 port read is pin level");
        check("R7 settled periph_din", periph_din, 8'h3C);

        // R7: exact two-edge latency.
        @(negedge clk); pin_in = 8'hC3;
        @(negedge clk);
        check("R7 not after one edge", periph_din, 8'h3C);
        @(negedge clk);
        check("R7 after two edges", periph_din, 8'hC3);

        // R4: pins 7 and 0 handed to the peripheral.
        @(negedge clk);
        periph_sel = 8'h81; periph_oe = 8'h80; periph_dout = 8'h01;
        #1;
        check("R4 override driver enable", pin_oe, 8'h8E);
        check("R4 override value", pin_out, 8'h25);

        // R5: read-modify-write of direction under override.
        bus_read(1'b1, 8'hF0, "R5 dir read under override");
        bus_write(1'b1, 8'hF0 ^ 8'h02);
        bus_read(1'b1, 8'hF2, "R5 RMW stores written word");
        #1;
        check("R5 enables after RMW", pin_oe, 8'h8C);
        @(negedge clk);
        periph_sel = 8'h00;
        #1;
        check("R5 latch untouched by override", pin_oe, 8'h0D);
        bus_read(1'b1, 8'hF2, "R5 dir after release");

        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule